// File: doc/BRIEF.md
# Carry Skip Adder with Inverting Skip Gates

This block adds two unsigned operands and a carry-in, producing a sum of the same width and a carry-out. The operand width is cut into equal blocks. Each block first forms a local sum with a ripple section that assumes no incoming carry. An increment section then adds the real incoming carry to that precomputed sum. Because the local sum is ready early, a late carry only has to pass through the short increment chain.

Carries move between blocks through a skip gate, not a multiplexer. The skip gate is a single inverting compound gate: either AND-OR-INVERT or OR-AND-INVERT. Each gate inverts what it passes on, so the carry line between blocks alternates between true and complemented form. Blocks that receive a true carry use the AND-OR-INVERT form. Blocks that receive a complemented carry use the OR-AND-INVERT form, which gives true polarity back. The final carry-out is corrected to true polarity whatever the number of blocks.

The adder itself is combinational. The top module adds one output register stage with a synchronous reset so that it can be tested.

Top module: `csk_adder`

## Requirements
- R1: On every clock edge where reset is low, the registered pair {cout, sum} takes the value a + b + cin, computed at full width with cout as the bit above sum's MSB.
- R2: An active-high synchronous reset clears sum and cout to zero at the next clock edge, whatever the operands are.
- R3: When every bit of a block propagates (a XOR b is all ones within the block), the true carry leaving that block equals the true carry entering it.
- R4: Carry lines are numbered from the carry-in, which is line 0. Each line holds the true carry when its index is even and the complement when its index is odd.
- R5: The carry-out is in true polarity whatever the block count is. This holds for both even and odd numbers of blocks.
- R6: A block's sum equals its carry-in-zero ripple sum plus the incoming true carry, with the result wrapping within the block. An all-ones operand plus a carry-in therefore clears every sum bit and sets cout.
- R7: A carry generated inside a block and then propagated to the block's top reaches the next block, even when that block's skip condition is false.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the test output register |
| rst | input | 1 | Synchronous active-high reset |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry-out, true polarity |

## Verification
The bench builds three copies of the adder, each with its own width and block size. A 16-bit copy with four 4-bit blocks takes random and directed operands. An 8-bit copy with four 2-bit blocks runs every combination of operands and carry-in, so every skip and generate pattern across four alternating stages is exercised. A 12-bit copy with three 4-bit blocks ends on a complemented carry line, which tests the correction of the final carry-out for an odd block count.

// File: rtl/csk_pkg.sv
package csk_pkg;

    // Polarity of inter-block carry line j (line 0 is the carry-in).
    // Each skip gate inverts, so odd-numbered lines hold the complement.
    function automatic logic line_inv(input int unsigned j);
        return logic'((j % 2) == 1);
    endfunction

    // Skip gate flavour chosen by the polarity of the carry it receives.
    typedef enum logic {
        SKIP_AOI = 1'b0,
        SKIP_OAI = 1'b1
    } skip_kind_e;

    function automatic skip_kind_e kind_for_line(input int unsigned j);
        return line_inv(j) ? SKIP_OAI : SKIP_AOI;
    endfunction

endpackage

// File: rtl/csk_ripple.sv
module csk_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] c;

    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign s[i]   = x[i] ^ y[i] ^ c[i];
        assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
    end

    assign co = c[W];
endmodule

// File: rtl/csk_incr.sv
module csk_incr #(
    parameter int W = 4
) (
    input  logic [W-1:0] base,
    input  logic         inc,
    output logic [W-1:0] res
);
    logic [W-1:0] t;

    assign t[0] = inc;

    for (genvar i = 0; i < W; i++) begin : g_ha
        assign res[i] = base[i] ^ t[i];
        if (i < W - 1) begin : g_next
            assign t[i+1] = base[i] & t[i];
        end
    end
endmodule

// File: rtl/csk_skip_gate.sv
module csk_skip_gate #(
    parameter csk_pkg::skip_kind_e KIND = csk_pkg::SKIP_AOI
) (
    input  logic prop_all,
    input  logic gen_local,
    input  logic c_line_in,
    output logic c_line_out
);
    if (KIND == csk_pkg::SKIP_AOI) begin : g_aoi
        // true carry in, complemented carry out
        assign c_line_out = ~((prop_all & c_line_in) | gen_local);
    end else begin : g_oai
        // complemented carry in, true carry out
        assign c_line_out = ~((~prop_all | c_line_in) & ~gen_local);
    end
endmodule

// File: rtl/csk_block.sv
module csk_block #(
    parameter int          BLK  = 4,
    parameter int unsigned LINE = 0
) (
    input  logic [BLK-1:0] a,
    input  logic [BLK-1:0] b,
    input  logic           c_line_in,
    output logic [BLK-1:0] sum,
    output logic           c_line_out,
    output logic           prop_all
);
    localparam logic IN_INV = csk_pkg::line_inv(LINE);
    localparam csk_pkg::skip_kind_e KIND = csk_pkg::kind_for_line(LINE);

    logic [BLK-1:0] sum0;
    logic           gen0;
    logic           c_true;

    assign prop_all = &(a ^ b);
    assign c_true   = IN_INV ? ~c_line_in : c_line_in;

    csk_ripple #(.W(BLK)) u_rip (
        .x (a),
        .y (b),
        .s (sum0),
        .co(gen0)
    );

    csk_incr #(.W(BLK)) u_inc (
        .base(sum0),
        .inc (c_true),
        .res (sum)
    );

    csk_skip_gate #(.KIND(KIND)) u_skip (
        .prop_all  (prop_all),
        .gen_local (gen0),
        .c_line_in (c_line_in),
        .c_line_out(c_line_out)
    );
endmodule

// File: rtl/csk_adder.sv
module csk_adder #(
    parameter int WIDTH = 16,
    parameter int BLK   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NBLK = WIDTH / BLK;
    localparam logic OUT_INV = csk_pkg::line_inv(NBLK);

    logic [NBLK:0]    carry_line;
    logic [NBLK-1:0]  blk_prop;
    logic [WIDTH-1:0] sum_c;
    logic             cout_c;

    assign carry_line[0] = cin;

    for (genvar k = 0; k < NBLK; k++) begin : g_blk
        csk_block #(
            .BLK (BLK),
            .LINE(k)
        ) u_blk (
            .a         (a[k*BLK +: BLK]),
            .b         (b[k*BLK +: BLK]),
            .c_line_in (carry_line[k]),
            .sum       (sum_c[k*BLK +: BLK]),
            .c_line_out(carry_line[k+1]),
            .prop_all  (blk_prop[k])
        );
    end

    assign cout_c = OUT_INV ? ~carry_line[NBLK] : carry_line[NBLK];

    always_ff @(posedge clk) begin
        if (rst) begin
            sum  <= '0;
            cout <= 1'b0;
        end else begin
            sum  <= sum_c;
            cout <= cout_c;
        end
    end
endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
    parameter int WIDTH = 16,
    parameter int BLK   = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic [WIDTH-1:0]       a,
    input logic [WIDTH-1:0]       b,
    input logic                   cin,
    input logic [WIDTH-1:0]       sum,
    input logic                   cout,
    input logic [WIDTH/BLK:0]     carry_line,
    input logic [WIDTH/BLK-1:0]   blk_prop
);
    localparam int NBLK = WIDTH / BLK;

    logic [WIDTH:0] true_line [NBLK+1];
    logic [WIDTH:0] ref_full;

    assign ref_full = {1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin);

    for (genvar j = 0; j <= NBLK; j++) begin : g_line
        localparam int LO = j * BLK;
        localparam logic [WIDTH:0] MASK = (WIDTH+1)'((64'd1 << LO) - 64'd1);
        localparam logic INV = csk_pkg::line_inv(j);

        assign true_line[j] = ({1'b0, a} & MASK) + ({1'b0, b} & MASK) + (WIDTH+1)'(cin);

        // R4: line polarity follows its index
        p_polarity_r4: assert property (@(posedge clk) disable iff (rst)
            (carry_line[j] ^ INV) == true_line[j][LO]);
    end

    for (genvar k = 0; k < NBLK; k++) begin : g_skip
        localparam logic INV_I = csk_pkg::line_inv(k);
        localparam logic INV_O = csk_pkg::line_inv(k + 1);
        // R3: fully propagating block passes its carry unchanged
        p_skip_pass_r3: assert property (@(posedge clk) disable iff (rst)
            blk_prop[k] |-> ((carry_line[k+1] ^ INV_O) == (carry_line[k] ^ INV_I)));
    end

    // R1: registered result equals the full-width sum of the prior inputs
    p_sum_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ({cout, sum} == $past(ref_full)));

    // R5: carry-out is the true carry above the MSB
    p_cout_true_r5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (cout == $past(ref_full[WIDTH])));

    // R2: reset clears the outputs
    p_reset_clear_r2: assert property (@(posedge clk)
        rst |=> (sum == '0 && cout == 1'b0));
endmodule

bind csk_adder csk_adder_chk #(.WIDTH(WIDTH), .BLK(BLK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .a         (a),
    .b         (b),
    .cin       (cin),
    .sum       (sum),
    .cout      (cout),
    .carry_line(carry_line),
    .blk_prop  (blk_prop)
);

// File: tb/sim_csk_adder.sv
module sim_csk_adder;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst;
    logic [15:0] a0, b0, s0;
    logic        c0, co0;
    logic [7:0]  a1, b1, s1;
    logic        c1, co1;
    logic [11:0] a2, b2, s2;
    logic        c2, co2;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    logic [16:0] q0[$];
    logic [8:0]  q1[$];
    logic [12:0] q2[$];
    string       qt[$];

    csk_adder #(.WIDTH(16), .BLK(4)) u0 (
        .clk(clk), .rst(rst), .a(a0), .b(b0), .cin(c0), .sum(s0), .cout(co0));
    csk_adder #(.WIDTH(8), .BLK(2)) u1 (
        .clk(clk), .rst(rst), .a(a1), .b(b1), .cin(c1), .sum(s1), .cout(co1));
    csk_adder #(.WIDTH(12), .BLK(4)) u2 (
        .clk(clk), .rst(rst), .a(a2), .b(b2), .cin(c2), .sum(s2), .cout(co2));

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 195000) begin
            errors++;
            $display("FAIL watchdog got %0d cycles exp completion", cycles);
            summary();
        end
    end

    task automatic drive(input logic [15:0] x0, y0, input logic z0,
                         input logic [7:0] x1, y1, input logic z1,
                         input logic [11:0] x2, y2, input logic z2,
                         input string tag);
        a0 = x0; b0 = y0; c0 = z0;
        a1 = x1; b1 = y1; c1 = z1;
        a2 = x2; b2 = y2; c2 = z2;
        q0.push_back(17'(x0) + 17'(y0) + 17'(z0));
        q1.push_back(9'(x1) + 9'(y1) + 9'(z1));
        q2.push_back(13'(x2) + 13'(y2) + 13'(z2));
        qt.push_back(tag);
    endtask

    task automatic compare();
        logic [16:0] e0;
        logic [8:0]  e1;
        logic [12:0] e2;
        string       t;
        if (qt.size() == 0) return;
        e0 = q0.pop_front(); e1 = q1.pop_front(); e2 = q2.pop_front();
        t  = qt.pop_front();
        checks += 3;
        if ({co0, s0} !== e0) begin
            errors++;
            $display("FAIL %s u0 got %h exp %h", t, {co0, s0}, e0);
        end
        if ({co1, s1} !== e1) begin
            errors++;
            $display("FAIL %s u1 got %h exp %h", t, {co1, s1}, e1);
        end
        if ({co2, s2} !== e2) begin
            errors++;
            $display("FAIL %s u2 got %h exp %h", t, {co2, s2}, e2);
        end
    endtask

    task automatic step(input logic [15:0] x0, y0, input logic z0,
                        input logic [7:0] x1, y1, input logic z1,
                        input logic [11:0] x2, y2, input logic z2,
                        input string tag);
        drive(x0, y0, z0, x1, y1, z1, x2, y2, z2, tag);
        @(negedge clk);
        compare();
    endtask

    task automatic check_zero(input string tag);
        checks++;
        if ({co0, s0, co1, s1, co2, s2} !== '0) begin
            errors++;
            $display("FAIL %s got %h exp 0", tag, {co0, s0, co1, s1, co2, s2});
        end
    endtask

    initial begin
        rst = 1'b1;
        a0 = '1; b0 = '1; c0 = 1'b1;
        a1 = '1; b1 = '1; c1 = 1'b1;
        a2 = '1; b2 = '1; c2 = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_zero("R2 reset state");
        rst = 1'b0;

        // R6: all ones plus carry-in wraps every block to zero
        step(16'hFFFF, 16'h0000, 1'b1, 8'hFF, 8'h00, 1'b1, 12'hFFF, 12'h000, 1'b1, "R6");
        // R3 R4: every block propagates, carry travels only through skip gates
        step(16'hAAAA, 16'h5555, 1'b1, 8'hAA, 8'h55, 1'b1, 12'hAAA, 12'h555, 1'b1, "R3 R4");
        step(16'hAAAA, 16'h5555, 1'b0, 8'hAA, 8'h55, 1'b0, 12'hAAA, 12'h555, 1'b0, "R3");
        // R7: local generate reaches the next block without a skip
        step(16'h000F, 16'h0001, 1'b0, 8'h03, 8'h01, 1'b0, 12'h00F, 12'h001, 1'b0, "R7");
        step(16'h0F00, 16'h0100, 1'b0, 8'h30, 8'h10, 1'b0, 12'h0F0, 12'h010, 1'b0, "R7");
        // R5: carry-out from top block, including odd block count
        step(16'h8000, 16'h8000, 1'b0, 8'h80, 8'h80, 1'b0, 12'h800, 12'h800, 1'b0, "R5");
        step(16'hFFFF, 16'hFFFF, 1'b1, 8'hFF, 8'hFF, 1'b1, 12'hFFF, 12'hFFF, 1'b1, "R5");
        step(16'h7FFF, 16'h8000, 1'b1, 8'h7F, 8'h80, 1'b1, 12'h7FF, 12'h800, 1'b1, "R5 R3");

        // R2: reset mid-run overrides live operands
        drive(16'h1234, 16'hFFFF, 1'b1, 8'hF0, 8'h1F, 1'b1, 12'hABC, 12'hFFF, 1'b1, "R2");
        void'(q0.pop_back()); void'(q1.pop_back()); void'(q2.pop_back()); void'(qt.pop_back());
        rst = 1'b1;
        @(negedge clk);
        check_zero("R2 mid-run reset");
        rst = 1'b0;

        // R1: exhaustive 8-bit, random 16-bit and 12-bit
        for (int i = 0; i < 131072; i++) begin
            logic [31:0] r0, r1;
            r0 = $urandom();
            r1 = $urandom();
            step(r0[15:0], r0[31:16], r1[0],
                 i[7:0], i[15:8], i[16],
                 r1[12:1], r1[24:13], r1[25], "R1");
        end
        summary();
    end
endmodule